// File: doc/BRIEF.md
# Time Slot Frame-Sync Assigner

This block produces frame-sync strobes for a group of PCM codecs that share one TDM highway. Each codec channel has a transmit strobe and a receive strobe. Each strobe goes high for the eight bit-clock periods of a time slot that is programmed for that channel and that direction. Transmit and receive timing run from two separate frame reference pulses. The two directions are counted independently, so a channel can be active in one direction only.

Slot numbers are loaded through a small serial port. While the select input is high, each rising edge of the serial clock shifts one bit in. A transfer that ends with exactly eight bits writes one 8-bit command into the channel chosen by the channel-select inputs. The command holds an enable bit, a direction bit and a 6-bit slot number. A combined transmit-active output is high whenever any channel's transmit strobe is high, so it can gate a highway driver.

The serial inputs are oversampled on the bit clock. Each serial-port level must therefore last at least one bit-clock period.

Top module: `tslot_sync_gen`

## Requirements
- R1: After reset every channel is disabled in both directions, and `tx_sync`, `rx_sync` and `tx_active` are all low.
- R2: A command is eight bits, shifted in MSB first on rising edges of `ser_clk` while `ser_cs` is high. Bit 7 is the enable bit. Bit 6 picks the direction: 1 for receive, 0 for transmit. Bits 5..0 are the slot number.
- R3: When `ser_cs` falls, a valid command updates only the channel whose index is on `ser_ch` at that moment, and only the direction named in bit 6.
- R4: A transfer that shifted any number of bits other than eight is discarded. No channel setting changes.
- R5: A slot whose enable bit was written as 0 keeps its strobe low in every cycle.
- R6: The rising bit-clock edge that samples `tx_fref` high sets the transmit bit count to 0. The count then rises by one per edge. While the count lies in 8*s .. 8*s+7, the transmit strobe of each channel enabled for slot s is high.
- R7: Receive strobes follow R6 using `rx_fref`, independently of `tx_fref` and of the transmit settings.
- R8: After bit count 511 (slot 63) every strobe of that direction stays low until the next reference pulse. A reference pulse in mid-frame restarts the count at 0.
- R9: `tx_active` is high exactly when at least one bit of `tx_sync` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial command clock, oversampled |
| ser_cs | input | 1 | Serial select, high during a transfer |
| ser_din | input | 1 | Serial command data |
| ser_ch | input | 2 | Channel addressed by the transfer |
| tx_fref | input | 1 | Transmit frame reference pulse |
| rx_fref | input | 1 | Receive frame reference pulse |
| tx_sync | output | 4 | Per-channel transmit frame-sync strobes |
| rx_sync | output | 4 | Per-channel receive frame-sync strobes |
| tx_active | output | 1 | High while any transmit strobe is high |

## Verification
The assertions rely on these input conditions:
- `ser_clk`, `ser_cs` and `ser_din` are quasi-static with respect to the bit clock, each holding a level for at least one period.
- `ser_ch` is stable at the falling edge of `ser_cs`.

The stimulus keeps to this by changing every input only on the falling bit-clock edge. It holds each serial level for a full period and sets `ser_ch` before raising select. The frame reference pulses are one bit clock wide. They are issued at arbitrary offsets, including mid-frame and while a serial transfer is in progress.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
package tsa_pkg;
   typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} tsa_dir_e;
   localparam int TSA_DEF_CHANNELS  = 4;
   localparam int TSA_DEF_SLOTS     = 64;
   localparam int TSA_DEF_SLOT_BITS = 8;
endpackage

// File: rtl/tsa_cfg_port.sv
`timescale 1ns/1ps
module tsa_cfg_port #(
   parameter int WORD_W = 8,
   parameter int CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_cs,
   input  logic              ser_din,
   input  logic [CH_W-1:0]   ser_ch,
   output logic              wr_stb,
   output logic [WORD_W-1:0] wr_word,
   output logic [CH_W-1:0]   wr_ch
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(WORD_W + 1);

   generate
      if (WORD_W < 3) begin : g_bad_word
         $error("tsa_cfg_port: WORD_W too small");
      end
   endgenerate

   logic              sclk_q, cs_q;
   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  nbits;
   logic              sclk_rise, cs_fall;

   assign sclk_rise = ser_clk & ~sclk_q;
   assign cs_fall   = cs_q & ~ser_cs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b0;
         shreg  <= '0;
         nbits  <= '0;
      end else begin
         sclk_q <= ser_clk;
         cs_q   <= ser_cs;
         if (ser_cs) begin
            if (sclk_rise) begin
               shreg <= {shreg[WORD_W-2:0], ser_din};
               if (nbits != CNT_CAP) nbits <= nbits + 1'b1;
            end
         end else begin
            nbits <= '0;
         end
      end
   end

   assign wr_stb  = cs_fall && (nbits == CNT_FULL);
   assign wr_word = shreg;
   assign wr_ch   = ser_ch;

   // R4: the bit counter saturates one past a full word, so over-long transfers never alias to a valid length
   a_r4_cnt_cap : assert property (@(posedge clk) disable iff (!rst_n)
      nbits <= CNT_CAP);
endmodule

// File: rtl/tsa_slot_bank.sv
`timescale 1ns/1ps
module tsa_slot_bank
   import tsa_pkg::*;
#(
   parameter int CHANNELS = 4,
   parameter int SLOT_W   = 6,
   localparam int CH_W    = $clog2(CHANNELS),
   localparam int WORD_W  = SLOT_W + 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_stb,
   input  logic [WORD_W-1:0]                wr_word,
   input  logic [CH_W-1:0]                  wr_ch,
   output logic [CHANNELS-1:0]              tx_en,
   output logic [CHANNELS-1:0][SLOT_W-1:0]  tx_slot,
   output logic [CHANNELS-1:0]              rx_en,
   output logic [CHANNELS-1:0][SLOT_W-1:0]  rx_slot
);
   logic     cmd_en;
   tsa_dir_e cmd_dir;
   assign cmd_en  = wr_word[SLOT_W+1];
   assign cmd_dir = tsa_dir_e'(wr_word[SLOT_W]);

   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
         logic hit;
         assign hit = wr_stb && (wr_ch == CH_W'(c));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_en[c]   <= 1'b0;
               tx_slot[c] <= '0;
               rx_en[c]   <= 1'b0;
               rx_slot[c] <= '0;
            end else if (hit) begin
               if (cmd_dir == DIR_RX) begin
                  rx_en[c]   <= cmd_en;
                  rx_slot[c] <= wr_word[SLOT_W-1:0];
               end else begin
                  tx_en[c]   <= cmd_en;
                  tx_slot[c] <= wr_word[SLOT_W-1:0];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tsa_frame_timer.sv
`timescale 1ns/1ps
module tsa_frame_timer #(
   parameter int SLOTS     = 64,
   parameter int SLOT_BITS = 8,
   localparam int SLOT_W   = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fref,
   output logic              running,
   output logic [SLOT_W-1:0] slot
);
   localparam int CNT_W = $clog2(SLOTS * SLOT_BITS);
   localparam int BIT_W = $clog2(SLOT_BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS * SLOT_BITS - 1);

   generate
      if ((1 << BIT_W) != SLOT_BITS || (1 << SLOT_W) != SLOTS) begin : g_bad_geom
         $error("tsa_frame_timer: SLOTS and SLOT_BITS must be powers of two");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (fref) begin
         cnt     <= '0;
         running <= 1'b1;
      end else if (running) begin
         if (cnt == LAST) running <= 1'b0;
         else             cnt     <= cnt + 1'b1;
      end
   end

   assign slot = cnt[CNT_W-1:BIT_W];

   // R6 / R8: a reference pulse always restarts the frame at bit 0
   a_r6_restart : assert property (@(posedge clk) disable iff (!rst_n)
      fref |=> (running && cnt == '0));
   // R8: counting halts after the last bit of the last slot
   a_r8_halt : assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt == LAST && !fref) |=> !running);
endmodule

// File: rtl/tsa_sync_decode.sv
`timescale 1ns/1ps
module tsa_sync_decode #(
   parameter int CHANNELS = 4,
   parameter int SLOT_W   = 6,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            running,
   input  logic [SLOT_W-1:0]               slot,
   input  logic [CHANNELS-1:0]             en,
   input  logic [CHANNELS-1:0][SLOT_W-1:0] slots,
   output logic [CHANNELS-1:0]             sync
);
   logic [CHANNELS-1:0] hit;

   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_hit
         assign hit[c] = running && en[c] && (slots[c] == slot);
      end

      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync <= '0;
            else        sync <= hit;
         end
      end else begin : g_comb
         assign sync = hit;

         // R8: an idle frame timer leaves every strobe low
         a_r8_idle : assert property (@(posedge clk) disable iff (!rst_n)
            !running |-> (sync == '0));
         for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
            // R5: a disabled slot never strobes
            a_r5_disabled : assert property (@(posedge clk) disable iff (!rst_n)
               !en[c] |-> !sync[c]);
         end
      end
   endgenerate
endmodule

// File: rtl/tslot_sync_gen.sv
`timescale 1ns/1ps
module tslot_sync_gen
   import tsa_pkg::*;
#(
   parameter int CHANNELS  = TSA_DEF_CHANNELS,
   parameter int SLOTS     = TSA_DEF_SLOTS,
   parameter int SLOT_BITS = TSA_DEF_SLOT_BITS,
   parameter bit OUT_REG   = 1'b0,
   localparam int CH_W     = $clog2(CHANNELS),
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int WORD_W   = SLOT_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_clk,
   input  logic                ser_cs,
   input  logic                ser_din,
   input  logic [CH_W-1:0]     ser_ch,
   input  logic                tx_fref,
   input  logic                rx_fref,
   output logic [CHANNELS-1:0] tx_sync,
   output logic [CHANNELS-1:0] rx_sync,
   output logic                tx_active
);
   generate
      if (CHANNELS < 2 || (1 << CH_W) != CHANNELS) begin : g_bad_ch
         $error("tslot_sync_gen: CHANNELS must be a power of two >= 2");
      end
   endgenerate

   logic                            wr_stb;
   logic [WORD_W-1:0]               wr_word;
   logic [CH_W-1:0]                 wr_ch;
   logic [CHANNELS-1:0]             tx_en, rx_en;
   logic [CHANNELS-1:0][SLOT_W-1:0] tx_slot, rx_slot;
   logic                            tx_run, rx_run;
   logic [SLOT_W-1:0]               tx_cur, rx_cur;

   tsa_cfg_port #(.WORD_W(WORD_W), .CH_W(CH_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs(ser_cs),
      .ser_din(ser_din), .ser_ch(ser_ch),
      .wr_stb(wr_stb), .wr_word(wr_word), .wr_ch(wr_ch));

   tsa_slot_bank #(.CHANNELS(CHANNELS), .SLOT_W(SLOT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word), .wr_ch(wr_ch),
      .tx_en(tx_en), .tx_slot(tx_slot), .rx_en(rx_en), .rx_slot(rx_slot));

   tsa_frame_timer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_tx_tmr (
      .clk(clk), .rst_n(rst_n), .fref(tx_fref), .running(tx_run), .slot(tx_cur));

   tsa_frame_timer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_rx_tmr (
      .clk(clk), .rst_n(rst_n), .fref(rx_fref), .running(rx_run), .slot(rx_cur));

   tsa_sync_decode #(.CHANNELS(CHANNELS), .SLOT_W(SLOT_W), .OUT_REG(OUT_REG)) u_tx_dec (
      .clk(clk), .rst_n(rst_n), .running(tx_run), .slot(tx_cur),
      .en(tx_en), .slots(tx_slot), .sync(tx_sync));

   tsa_sync_decode #(.CHANNELS(CHANNELS), .SLOT_W(SLOT_W), .OUT_REG(OUT_REG)) u_rx_dec (
      .clk(clk), .rst_n(rst_n), .running(rx_run), .slot(rx_cur),
      .en(rx_en), .slots(rx_slot), .sync(rx_sync));

   assign tx_active = |tx_sync;
endmodule

// File: tb/test_tslot_sync_gen.sv
`timescale 1ns/1ps
module test_tslot_sync_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0, ser_cs = 1'b0, ser_din = 1'b0;
   logic [1:0] ser_ch = 2'd0;
   logic       tx_fref = 1'b0, rx_fref = 1'b0;
   logic [3:0] tx_sync, rx_sync;
   logic       tx_active;

   always #4 clk = ~clk;   // 125 MHz

   tslot_sync_gen i_tslot_sync_gen (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs(ser_cs),
      .ser_din(ser_din), .ser_ch(ser_ch), .tx_fref(tx_fref), .rx_fref(rx_fref),
      .tx_sync(tx_sync), .rx_sync(rx_sync), .tx_active(tx_active));

   int errors = 0, checks = 0;
   bit done = 0;
   string cur_tag = "R1";

   // model of the requirements
   bit ten[4], ren[4];
   int tsl[4], rsl[4];
   int tcnt = 0, rcnt = 0;
   bit trun = 0, rrun = 0;

   // table: {channel[9:8], enable[7], dir[6] (1 = receive), slot[5:0]}
   localparam logic [9:0] VEC [8] = '{
      {2'd0, 1'b1, 1'b0, 6'd0},
      {2'd1, 1'b1, 1'b0, 6'd5},
      {2'd2, 1'b1, 1'b1, 6'd3},
      {2'd3, 1'b1, 1'b1, 6'd63},
      {2'd3, 1'b1, 1'b0, 6'd63},
      {2'd0, 1'b1, 1'b1, 6'd1},
      {2'd1, 1'b0, 1'b1, 6'd7},
      {2'd2, 1'b1, 1'b0, 6'd5}
   };

   task automatic compare();
      logic [3:0] et, er;
      logic [8:0] act, exp;
      for (int c = 0; c < 4; c++) begin
         et[c] = trun && ten[c] && (tcnt / 8 == tsl[c]);
         er[c] = rrun && ren[c] && (rcnt / 8 == rsl[c]);
      end
      act = {tx_active, rx_sync, tx_sync};
      exp = {|et, er, et};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {tx_active,rx_sync,tx_sync} actual=%b expected=%b (tcnt=%0d rcnt=%0d)",
                  cur_tag, act, exp, tcnt, rcnt);
      end
   endtask

   // one bit clock: model follows the rising edge, outputs checked at the falling edge
   task automatic step();
      @(posedge clk);
      if (tx_fref) begin tcnt = 0; trun = 1; end
      else if (trun) begin if (tcnt == 511) trun = 0; else tcnt++; end
      if (rx_fref) begin rcnt = 0; rrun = 1; end
      else if (rrun) begin if (rcnt == 511) rrun = 0; else rcnt++; end
      @(negedge clk);
      if (rst_n) compare();
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // shift the top nbits of pat, MSB first; commit in the model only for 8 bits
   task automatic cfg_send(input logic [1:0] ch, input logic [15:0] pat, input int nbits);
      ser_ch = ch;
      ser_cs = 1'b1;
      step();
      for (int i = 0; i < nbits; i++) begin
         ser_din = pat[15-i];
         ser_clk = 1'b0; step();
         ser_clk = 1'b1; step();
      end
      ser_clk = 1'b0;
      ser_cs  = 1'b0;
      if (nbits == 8) begin
         if (pat[14]) begin ren[ch] = pat[15]; rsl[ch] = int'(pat[13:8]); end
         else         begin ten[ch] = pat[15]; tsl[ch] = int'(pat[13:8]); end
      end
      steps(2);
   endtask

   task automatic pulse_tx(); tx_fref = 1'b1; step(); tx_fref = 1'b0; endtask
   task automatic pulse_rx(); rx_fref = 1'b1; step(); rx_fref = 1'b0; endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      for (int c = 0; c < 4; c++) begin ten[c] = 0; ren[c] = 0; tsl[c] = 0; rsl[c] = 0; end
      // R1: reset state, then frames with nothing enabled
      cur_tag = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      steps(2);
      pulse_tx(); pulse_rx();
      steps(40);

      // vector table: R2 command format, R3 channel addressing
      cur_tag = "R2 R3 table";
      for (int v = 0; v < 8; v++)
         cfg_send(VEC[v][9:8], {VEC[v][7:0], 8'h00}, 8);

      // R6 transmit timing, R7 independent receive timing, R9 tx_active
      cur_tag = "R6 R7 R9 frame";
      pulse_tx();
      steps(37);
      pulse_rx();
      steps(480);
      // R8: tail of the frame and the idle time after slot 63
      cur_tag = "R8 end of frame";
      steps(120);

      // R4: short and long transfers are discarded
      cur_tag = "R4 bad length";
      cfg_send(2'd0, 16'h0000, 7);
      cfg_send(2'd0, 16'h0000, 9);
      cfg_send(2'd2, 16'h4A00, 1);
      pulse_tx(); pulse_rx();
      steps(100);

      // R5: disabling channel 1 transmit, configured while a frame runs
      cur_tag = "R5 disable";
      cfg_send(2'd1, {1'b0, 1'b0, 6'd5, 8'h00}, 8);
      pulse_tx();
      steps(60);

      // R8: restart mid-frame
      cur_tag = "R8 restart";
      steps(200);
      pulse_tx();
      steps(30);
      pulse_rx();
      steps(530);

      // R3: rewrite channel 3 receive to slot 2 while channel 3 transmit stays
      cur_tag = "R3 rewrite";
      cfg_send(2'd3, {1'b1, 1'b1, 6'd2, 8'h00}, 8);
      pulse_tx(); pulse_rx();
      steps(520);

      done = 1;
      finish_run();
   end
endmodule